// File: doc/BRIEF.md
# Multisample Depth-Test and Resolve Engine

This block processes fragments for single pixels of a multisampled frame. A fragment carries a pixel index, a coverage mask with one bit per subsample, an RGBA colour, a depth value at the pixel centre, and two signed depth slopes. For each subsample, the engine reconstructs the depth at that subsample's fixed position on an 8x8 sub-pixel grid. Only covered subsamples are tested against the depth held in an internal per-pixel subsample store. Where a covered subsample is nearer, the engine replaces both its stored colour and its stored depth.

Once every subsample has been visited, the engine averages the colours of all subsamples of the pixel. It writes this resolved colour to a displayable buffer, which has its own read port, and also presents it on a result port together with a one-cycle completion pulse. Subsamples are visited one per clock. A new fragment is refused until the completion pulse appears. With parameters, the engine supports either 8 samples with 12-bit channels and 32-bit depth, or 16 samples with 8-bit channels and 24-bit depth.

Top module: `ms_depth_resolve`

## Requirements
- R1: After reset, the engine initialises every stored subsample to colour 0 and depth all-ones, and every display entry to 0. During this initialisation, which lasts PIX*SAMPLES cycles, `frag_ready` is low.
- R2: Subsample i sits at offset dx = ((3*i+1) mod 8) - 4 and dy = ((5*i + 2 + floor(i/8)) mod 8) - 4. Both offsets are in signed eighths of a pixel, and every pixel uses the same pattern.
- R3: The depth of subsample i is zc + floor((dzdx*dx + dzdy*dy)/8). Results below 0 clamp to 0, and results above 2^ZW-1 clamp to 2^ZW-1.
- R4: A subsample whose mask bit is 0 keeps its stored colour and depth, whatever its computed depth.
- R5: A covered subsample passes only when its computed depth is strictly less than the stored depth. When the two are equal, the stored values are kept.
- R6: On a pass, the subsample's stored colour becomes the fragment colour and its stored depth becomes the computed depth.
- R7: The resolved colour is computed for each channel separately: it is the sum over all SAMPLES stored colours, shifted right by log2(SAMPLES). Colours are packed {R,G,B,A}, with R in the top CW bits. The resolved colour appears on `done_rgba` and is written to the display buffer at the fragment's pixel index.
- R8: `done` is a one-cycle pulse. It is first high SAMPLES+2 rising edges after the edge that accepts the fragment, and `done_pix` carries the accepted pixel index.
- R9: `frag_ready` falls on the edge after acceptance and is high again in the cycle where `done` is high.
- R10: The display read port returns the entry at `disp_raddr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frag_valid | input | 1 | Fragment present |
| frag_ready | output | 1 | Engine can accept a fragment |
| frag_pix | input | log2(PIX) | Pixel index |
| frag_mask | input | SAMPLES | Coverage mask, bit i is subsample i |
| frag_rgba | input | 4*CW | Fragment colour {R,G,B,A} |
| frag_z | input | ZW | Depth at pixel centre (unsigned) |
| frag_dzdx | input | SW | Signed depth slope along x |
| frag_dzdy | input | SW | Signed depth slope along y |
| done | output | 1 | Resolve completed pulse |
| done_pix | output | log2(PIX) | Pixel that was resolved |
| done_rgba | output | 4*CW | Resolved colour |
| disp_raddr | input | log2(PIX) | Display buffer read address |
| disp_rdata | output | 4*CW | Display buffer read data |

## Verification
The bench targets several corner cases, each with a characteristic failure:
- Equal depths. A design using less-or-equal would overwrite the stored colour and change the resolved value.
- An empty coverage mask. A design that ignores the mask would paint every subsample.
- Steep slopes that push subsample depth past either end of the range. A design with a missing clamp would wrap around and pass samples it should reject, or reject samples it should pass.
- Partial masks whose neighbouring channels all carry high values. An average that lets a carry spill across channel fields, or that uses the wrong shift, would produce the wrong colour.
- Back-to-back fragments at random. These expose a wrong latency or a stall that releases early.

// File: rtl/msr_pkg.sv
package msr_pkg;
  // Fixed subsample offsets on the 8x8 grid, signed eighths of a pixel.
  function automatic logic signed [3:0] sub_dx(input int unsigned i);
    int unsigned g;
    g = (3 * i + 1) % 8;
    return 4'(int'(g) - 4);
  endfunction

  function automatic logic signed [3:0] sub_dy(input int unsigned i);
    int unsigned g;
    g = (5 * i + 2 + i / 8) % 8;
    return 4'(int'(g) - 4);
  endfunction

  typedef enum logic [1:0] {ST_CLR, ST_IDLE, ST_RUN, ST_RES} msr_state_t;
endpackage

// File: rtl/msr_ram.sv
module msr_ram #(
  parameter int W  = 8,
  parameter int D  = 16,
  parameter int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/msr_depth_unit.sv
module msr_depth_unit #(
  parameter int ZW = 32,
  parameter int SW = 16
) (
  input  logic [ZW-1:0]        zc,
  input  logic signed [SW-1:0] dzdx,
  input  logic signed [SW-1:0] dzdy,
  input  logic signed [3:0]    dx,
  input  logic signed [3:0]    dy,
  input  logic [ZW-1:0]        z_stored,
  input  logic                 covered,
  output logic [ZW-1:0]        z_sample,
  output logic                 pass
);
  localparam int PW = SW + 5;
  localparam int FW = ZW + 2;

  logic signed [PW-1:0] sx_e, sy_e, ox_e, oy_e, px, py;
  logic signed [PW:0]   sum, sh;
  logic signed [FW-1:0] ofs, zfull;

  always_comb begin
    sx_e  = {{5{dzdx[SW-1]}}, dzdx};
    sy_e  = {{5{dzdy[SW-1]}}, dzdy};
    ox_e  = {{(PW-4){dx[3]}}, dx};
    oy_e  = {{(PW-4){dy[3]}}, dy};
    px    = sx_e * ox_e;
    py    = sy_e * oy_e;
    sum   = {px[PW-1], px} + {py[PW-1], py};
    sh    = sum >>> 3;
    ofs   = {{(FW-PW-1){sh[PW]}}, sh};
    zfull = $signed({2'b00, zc}) + ofs;
    if (zfull[FW-1])      z_sample = '0;
    else if (zfull[ZW])   z_sample = '1;
    else                  z_sample = zfull[ZW-1:0];
    pass = covered && (z_sample < z_stored);
  end
endmodule

// File: rtl/msr_avg.sv
module msr_avg #(
  parameter int CW = 12,
  parameter int LS = 3,
  parameter int AC = CW + LS
) (
  input  logic [4*AC-1:0] acc,
  output logic [4*CW-1:0] rgba
);
  for (genvar c = 0; c < 4; c++) begin : g_ch
    assign rgba[c*CW +: CW] = acc[c*AC + LS +: CW];
  end
endmodule

// File: rtl/ms_depth_resolve.sv
module ms_depth_resolve #(
  parameter int SAMPLES = 8,
  parameter int CW      = 12,
  parameter int ZW      = 32,
  parameter int SW      = 16,
  parameter int PIX     = 16,
  parameter int PW      = $clog2(PIX)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frag_valid,
  output logic                 frag_ready,
  input  logic [PW-1:0]        frag_pix,
  input  logic [SAMPLES-1:0]   frag_mask,
  input  logic [4*CW-1:0]      frag_rgba,
  input  logic [ZW-1:0]        frag_z,
  input  logic signed [SW-1:0] frag_dzdx,
  input  logic signed [SW-1:0] frag_dzdy,
  output logic                 done,
  output logic [PW-1:0]        done_pix,
  output logic [4*CW-1:0]      done_rgba,
  input  logic [PW-1:0]        disp_raddr,
  output logic [4*CW-1:0]      disp_rdata
);
  import msr_pkg::*;

  localparam int LS   = $clog2(SAMPLES);
  localparam int AW   = PW + LS;
  localparam int RGBW = 4 * CW;
  localparam int EW   = RGBW + ZW;
  localparam int AC   = CW + LS;
  localparam logic [AW-1:0] CLR_LAST = AW'(PIX * SAMPLES - 1);

  msr_state_t state;
  logic [PW-1:0]        f_pix;
  logic [SAMPLES-1:0]   f_mask;
  logic [RGBW-1:0]      f_rgba;
  logic [ZW-1:0]        f_z;
  logic signed [SW-1:0] f_dzdx, f_dzdy;
  logic [LS:0]          cnt;
  logic [AW-1:0]        clr_addr;
  logic [4*AC-1:0]      acc;

  logic [LS-1:0]   pidx;
  logic            proc;
  logic [EW-1:0]   st_rdata, st_wdata;
  logic [AW-1:0]   st_waddr, st_raddr;
  logic            st_we;
  logic [ZW-1:0]   z_samp;
  logic            pass;
  logic [RGBW-1:0] pick, avg, dp_wdata;
  logic [PW-1:0]   dp_waddr;
  logic            dp_we;

  assign frag_ready = (state == ST_IDLE);
  assign pidx       = LS'(cnt - 1'b1);
  assign proc       = (state == ST_RUN) && (cnt != '0);
  assign st_raddr   = {f_pix, cnt[LS-1:0]};
  assign pick       = pass ? f_rgba : st_rdata[EW-1:ZW];

  msr_depth_unit #(.ZW(ZW), .SW(SW)) u_depth (
    .zc(f_z), .dzdx(f_dzdx), .dzdy(f_dzdy),
    .dx(sub_dx(32'(pidx))), .dy(sub_dy(32'(pidx))),
    .z_stored(st_rdata[ZW-1:0]), .covered(f_mask[pidx]),
    .z_sample(z_samp), .pass(pass)
  );

  msr_avg #(.CW(CW), .LS(LS), .AC(AC)) u_avg (.acc(acc), .rgba(avg));

  always_comb begin
    st_we    = 1'b0;
    st_waddr = {f_pix, pidx};
    st_wdata = {f_rgba, z_samp};
    dp_we    = 1'b0;
    dp_waddr = f_pix;
    dp_wdata = avg;
    if (state == ST_CLR) begin
      st_we    = 1'b1;
      st_waddr = clr_addr;
      st_wdata = {{RGBW{1'b0}}, {ZW{1'b1}}};
      dp_we    = 1'b1;
      dp_waddr = clr_addr[PW-1:0];
      dp_wdata = '0;
    end else if (proc) begin
      st_we = pass;
    end else if (state == ST_RES) begin
      dp_we = 1'b1;
    end
  end

  msr_ram #(.W(EW), .D(PIX * SAMPLES), .AW(AW)) u_store (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
    .raddr(st_raddr), .rdata(st_rdata)
  );

  msr_ram #(.W(RGBW), .D(PIX), .AW(PW)) u_disp (
    .clk(clk), .we(dp_we), .waddr(dp_waddr), .wdata(dp_wdata),
    .raddr(disp_raddr), .rdata(disp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CLR;
      clr_addr  <= '0;
      cnt       <= '0;
      acc       <= '0;
      f_pix     <= '0;
      f_mask    <= '0;
      f_rgba    <= '0;
      f_z       <= '0;
      f_dzdx    <= '0;
      f_dzdy    <= '0;
      done      <= 1'b0;
      done_pix  <= '0;
      done_rgba <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_CLR: begin
          clr_addr <= clr_addr + 1'b1;
          if (clr_addr == CLR_LAST) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (frag_valid) begin
            f_pix  <= frag_pix;
            f_mask <= frag_mask;
            f_rgba <= frag_rgba;
            f_z    <= frag_z;
            f_dzdx <= frag_dzdx;
            f_dzdy <= frag_dzdy;
            cnt    <= '0;
            acc    <= '0;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (proc) begin
            for (int c = 0; c < 4; c++)
              acc[c*AC +: AC] <= acc[c*AC +: AC] + {{LS{1'b0}}, pick[c*CW +: CW]};
          end
          if (cnt == (LS+1)'(SAMPLES)) state <= ST_RES;
        end
        default: begin
          done      <= 1'b1;
          done_pix  <= f_pix;
          done_rgba <= avg;
          state     <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/msr_checker.sv
module msr_checker #(
  parameter int SAMPLES = 8,
  parameter int RGBW    = 48
) (
  input logic            clk,
  input logic            rst,
  input logic            frag_valid,
  input logic            frag_ready,
  input logic            done,
  input logic [RGBW-1:0] done_rgba
);
  logic [7:0] lat;

  always_ff @(posedge clk) begin
    if (rst)                          lat <= '0;
    else if (frag_valid && frag_ready) lat <= 8'd1;
    else if (done)                    lat <= '0;
    else if (lat != '0)               lat <= lat + 8'd1;
  end

  // R8: completion arrives SAMPLES+2 edges after acceptance
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat == 8'(SAMPLES + 3)));

  // R8: single-cycle pulse
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: stall after acceptance
  a_r9_stall: assert property (@(posedge clk) disable iff (rst)
    (frag_valid && frag_ready) |=> !frag_ready);

  // R9: ready again in the completion cycle
  a_r9_ready_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> frag_ready);

  // R7: resolved colour only changes with completion
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(done_rgba));
endmodule

bind ms_depth_resolve msr_checker #(.SAMPLES(SAMPLES), .RGBW(4*CW)) u_chk (
  .clk(clk), .rst(rst), .frag_valid(frag_valid), .frag_ready(frag_ready),
  .done(done), .done_rgba(done_rgba)
);

// File: tb/sim_ms_depth_resolve.sv
module sim_ms_depth_resolve;
  localparam int S    = 8;
  localparam int CW   = 12;
  localparam int ZW   = 32;
  localparam int SW   = 16;
  localparam int PIX  = 16;
  localparam int PW   = $clog2(PIX);
  localparam int LS   = $clog2(S);
  localparam int RGBW = 4 * CW;
  localparam time TCLK = 10ns;
  localparam longint ZMAX = (64'd1 << ZW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frag_valid = 1'b0;
  logic frag_ready;
  logic [PW-1:0] frag_pix = '0;
  logic [S-1:0] frag_mask = '0;
  logic [RGBW-1:0] frag_rgba = '0;
  logic [ZW-1:0] frag_z = '0;
  logic signed [SW-1:0] frag_dzdx = '0, frag_dzdy = '0;
  logic done;
  logic [PW-1:0] done_pix;
  logic [RGBW-1:0] done_rgba;
  logic [PW-1:0] disp_raddr = '0;
  logic [RGBW-1:0] disp_rdata;

  int errors = 0;
  int checks = 0;

  longint mz [PIX][S];
  logic [RGBW-1:0] mc [PIX][S];
  logic [RGBW-1:0] md [PIX];

  always #(TCLK/2) clk = ~clk;

  ms_depth_resolve #(.SAMPLES(S), .CW(CW), .ZW(ZW), .SW(SW), .PIX(PIX)) u0 (
    .clk(clk), .rst(rst), .frag_valid(frag_valid), .frag_ready(frag_ready),
    .frag_pix(frag_pix), .frag_mask(frag_mask), .frag_rgba(frag_rgba),
    .frag_z(frag_z), .frag_dzdx(frag_dzdx), .frag_dzdy(frag_dzdy),
    .done(done), .done_pix(done_pix), .done_rgba(done_rgba),
    .disp_raddr(disp_raddr), .disp_rdata(disp_rdata)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2 offsets and R3 depth with floor and clamp
  function automatic longint samp_z(longint zc, int dzdx, int dzdy, int i);
    longint dx, dy, p, z;
    dx = longint'((3*i + 1) % 8) - 4;
    dy = longint'((5*i + 2 + i/8) % 8) - 4;
    p  = (longint'(dzdx) * dx + longint'(dzdy) * dy) >>> 3;
    z  = zc + p;
    if (z < 0) z = 0;
    if (z > ZMAX) z = ZMAX;
    return z;
  endfunction

  function automatic logic [RGBW-1:0] resolve(int pix);
    logic [RGBW-1:0] r;
    for (int c = 0; c < 4; c++) begin
      longint sum = 0;
      for (int i = 0; i < S; i++) sum += longint'(mc[pix][i][c*CW +: CW]);
      r[c*CW +: CW] = CW'(sum >> LS);
    end
    return r;
  endfunction

  task automatic read_disp(input int pix, input string tag);
    @(negedge clk);
    disp_raddr = PW'(pix);
    @(negedge clk);
    check(disp_rdata == md[pix], {tag, " R10 display"}, longint'(disp_rdata), longint'(md[pix]));
  endtask

  task automatic send(input int pix, input logic [S-1:0] mask, input logic [RGBW-1:0] col,
                      input longint zc, input int dzdx, input int dzdy, input string tag);
    int lat;
    logic [RGBW-1:0] exp_c;
    @(negedge clk);
    frag_valid = 1'b1;
    frag_pix   = PW'(pix);
    frag_mask  = mask;
    frag_rgba  = col;
    frag_z     = ZW'(zc);
    frag_dzdx  = SW'(dzdx);
    frag_dzdy  = SW'(dzdy);
    while (!frag_ready) @(negedge clk);
    @(posedge clk);
    #1 frag_valid = 1'b0;
    for (int i = 0; i < S; i++) begin
      longint z = samp_z(zc, dzdx, dzdy, i);
      if (mask[i] && z < mz[pix][i]) begin
        mz[pix][i] = z;
        mc[pix][i] = col;
      end
    end
    exp_c = resolve(pix);
    md[pix] = exp_c;
    lat = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      if (lat == 1) check(!frag_ready, {tag, " R9 stall"}, longint'(frag_ready), 0);
      if (done || lat > 60) break;
    end
    check(lat == S + 3, {tag, " R8 latency"}, lat, S + 3);
    check(frag_ready, {tag, " R9 ready at done"}, longint'(frag_ready), 1);
    check(done_pix == PW'(pix), {tag, " R8 pixel"}, longint'(done_pix), pix);
    check(done_rgba == exp_c, {tag, " R7 resolved"}, longint'(done_rgba), longint'(exp_c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int cyc;
    void'($urandom(32'd4242));
    for (int p = 0; p < PIX; p++) begin
      md[p] = '0;
      for (int i = 0; i < S; i++) begin
        mz[p][i] = ZMAX;
        mc[p][i] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    @(negedge clk);
    while (!frag_ready && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    // R1: initialisation lasts PIX*S cycles
    check(cyc >= PIX * S - 2 && cyc <= PIX * S + 1, "R1 clear time", cyc, PIX * S);
    read_disp(0, "R1 cleared");
    read_disp(PIX - 1, "R1 cleared");

    send(5, '0, 48'hFFF_FFF_FFF_FFF, 100, 0, 0, "R4 empty mask");
    read_disp(5, "R4 empty mask");
    send(1, '1, 48'h123_456_789_ABC, 100, 0, 0, "R6 full cover");
    send(1, '1, 48'hFFF_000_FFF_000, 100, 0, 0, "R5 equal depth");
    send(1, S'(8'h0F), 48'hFFF_FFF_FFF_FFF, 99, 0, 0, "R4 partial mask");
    read_disp(1, "R7 partial");
    send(2, '1, 48'h100_200_300_400, 100, 0, 0, "R6 flat base");
    send(2, '1, 48'hAAA_555_AAA_555, 100, 80, -48, "R2 R3 slopes");
    send(3, '1, 48'h0F0_0F0_0F0_0F0, ZMAX - 1, 32767, 32767, "R3 clamp high");
    send(4, '1, 48'h800_800_800_800, 1, -32768, -32768, "R3 clamp low");
    send(4, '1, 48'h001_002_003_004, 0, 0, 0, "R5 at zero");
    send(6, S'(8'hA5), 48'hFFF_FFF_FFF_FFF, 500, 0, 0, "R7 carry isolate");
    read_disp(6, "R7 carry isolate");

    for (int n = 0; n < 200; n++) begin
      logic [RGBW-1:0] col;
      col = RGBW'({$urandom, $urandom});
      send(int'($urandom_range(0, 3)) + 8, S'($urandom), col,
           longint'($urandom_range(2000, 6000)),
           int'($urandom_range(0, 800)) - 400, int'($urandom_range(0, 800)) - 400,
           "R3 R6 R7 random");
      if (n % 20 == 0) read_disp(8 + (n / 20) % 4, "R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule